// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block collects interrupt events for a network controller and drives one level-sensitive interrupt line. Event sources inside the controller, such as link change, PHY access complete, transmit write-back, transmit queue empty, receive overrun, receive threshold and packet received, each pulse one input bit. The block ORs these pulses into a 32-bit cause register. Software sees the cause through a small word-addressed register port. It can read the cause, which also clears it. It can set cause bits through an alias address, and it can clear cause bits by writing ones.

A 32-bit mask register decides which causes reach the line. Software sets mask bits and clears them through two separate addresses, so neither operation needs a read-modify-write. Whenever the stored cause is nonzero, the top bit acts as a summary flag and is forced high. The interrupt line is registered, and it is high exactly when mask and cause share a set bit.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the cause register and the mask register read zero, and irq_o is low.
- R2: A 1 on event input bit k makes cause bit k read 1 from the next cycle on.
- R3: Whenever the stored cause value is nonzero, its bit 31 is 1.
- R4: A read at address 1 (cause-set alias) returns the current cause value and leaves it unchanged.
- R5: A write at address 1 ORs the write data into the cause register.
- R6: A write at address 0 clears each cause bit whose data bit is 1 (write-one-to-clear).
- R7: A read at address 0 returns the current cause value in the same cycle, and the cause register becomes zero on the following clock edge.
- R8: A write at address 2 ORs the data into the mask, and a write at address 3 clears the mask bits that are 1 in the data. A read at address 2 or 3 returns the mask.
- R9: irq_o is a register output. In every cycle after reset it equals the OR-reduction of (mask AND cause) as both registers stand after the last clock edge. It therefore follows any register change one cycle after the access that made it.
- R10: An event bit that arrives in the same cycle as a clearing read or a write-one-to-clear of that bit is kept in the cause register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address: 0 cause, 1 cause-set, 2 mask-set, 3 mask-clear |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the cycle of reg_rd |
| evt_i | input | EVT_W | Event pulses, bit k sets cause bit k |
| irq_o | output | 1 | Level interrupt line |

## Verification
The bench targets an event that lands in the same cycle as a clearing read or a write-one-to-clear. A design that lets the clear win would drop that interrupt without a trace. It also checks the summary bit in two cases: after other causes are cleared while bit 31 stays set, and after bit 31 itself is cleared while other causes remain. A design that derives the bit wrongly would report a stale or missing summary. A mask-clear write must drop irq_o exactly one cycle later. Reads through the alias address must not clear anything, otherwise a later read of the cause would show lost bits.

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl #(
  parameter int EVT_W  = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  evt_i,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CSET  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(3);
  localparam logic [DATA_W-1:0] SUMMARY = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] cause_q, mask_q, cause_raw, cause_d, mask_d, evt_ext;
  logic irq_q;

  wire rd_cause = reg_rd && reg_addr == A_CAUSE;
  wire wr_cause = reg_wr && reg_addr == A_CAUSE;
  wire wr_cset  = reg_wr && reg_addr == A_CSET;
  wire wr_mset  = reg_wr && reg_addr == A_MSET;
  wire wr_mclr  = reg_wr && reg_addr == A_MCLR;

  assign evt_ext   = {{(DATA_W-EVT_W){1'b0}}, evt_i};
  assign cause_raw = ((rd_cause ? '0 : cause_q) & ~(wr_cause ? reg_wdata : '0))
                   | (wr_cset ? reg_wdata : '0) | evt_ext;
  assign cause_d   = (|cause_raw) ? (cause_raw | SUMMARY) : cause_raw;
  assign mask_d    = (mask_q | (wr_mset ? reg_wdata : '0)) & ~(wr_mclr ? reg_wdata : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      mask_q  <= mask_d;
      irq_q   <= |(cause_d & mask_d);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == A_CAUSE || reg_addr == A_CSET) reg_rdata = cause_q;
      else if (reg_addr == A_MSET || reg_addr == A_MCLR) reg_rdata = mask_q;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk #(
  parameter int EVT_W  = 7,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [EVT_W-1:0]  evt_i,
  input logic [DATA_W-1:0] cause,
  input logic [DATA_W-1:0] mask,
  input logic              irq_o
);
  a_r3_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (cause != '0) |-> cause[DATA_W-1]);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(0) && !reg_wr && evt_i == '0) |=> cause == '0);

  a_r10_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> (cause[EVT_W-1:0] & $past(evt_i)) == $past(evt_i));

  a_r5_set_or: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(1)) |=> (cause & $past(reg_wdata)) == $past(reg_wdata));

  a_r8_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(3)) |=> (mask & $past(reg_wdata)) == '0);

  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(mask & cause));
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(.EVT_W(EVT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .evt_i(evt_i), .cause(cause_q), .mask(mask_q), .irq_o(irq_o)
);

// File: tb/tb_irq_cause_ctrl.sv
module tb_irq_cause_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int EVT_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [EVT_W-1:0] evt_i = '0;
  logic irq_o;

  int checks = 0, failures = 0;
  logic [31:0] m_cause = '0, m_mask = '0;
  bit done = 0;

  irq_cause_ctrl #(.EVT_W(EVT_W), .DATA_W(32), .ADDR_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [1:0] a,
                      input logic [31:0] d, input logic [EVT_W-1:0] e, input string req);
    logic [31:0] nc;
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; evt_i = e;
    #1;
    if (r) check(req, reg_rdata, (a < 2) ? m_cause : m_mask);
    @(posedge clk);
    nc = m_cause;
    if (r && a == 0) nc = '0;
    if (w && a == 0) nc = nc & ~d;
    if (w && a == 1) nc = nc | d;
    nc = nc | {{(32-EVT_W){1'b0}}, e};
    if (nc != 0) nc[31] = 1'b1;
    m_cause = nc;
    if (w && a == 2) m_mask = m_mask | d;
    if (w && a == 3) m_mask = m_mask & ~d;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; evt_i = '0;
    check("R9 irq", {31'b0, irq_o}, {31'b0, |(m_cause & m_mask)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    step(0, 1, 2'd1, 0, 0, "R1 cause");
    step(0, 1, 2'd2, 0, 0, "R1 mask");
    step(0, 0, 2'd0, 0, 7'h04, "R2 event");
    step(0, 1, 2'd1, 0, 0, "R2 R3 R4 alias read");
    check("R4 alias keeps", m_cause, 32'h8000_0004);
    step(0, 1, 2'd1, 0, 0, "R4 alias no clear");
    step(1, 0, 2'd2, 32'h0000_0004, 0, "R8 mask set");
    step(0, 1, 2'd3, 0, 0, "R8 mask read");
    step(1, 0, 2'd3, 32'h0000_0004, 0, "R8 R9 mask clear");
    check("R9 dropped", {31'b0, irq_o}, 32'h0);
    step(1, 0, 2'd1, 32'h0000_0100, 0, "R5 set");
    step(0, 1, 2'd1, 0, 0, "R5 readback");
    step(1, 0, 2'd0, 32'h0000_0004, 0, "R6 w1c");
    step(0, 1, 2'd1, 0, 0, "R6 readback");
    step(1, 0, 2'd0, 32'h0000_0100, 0, "R3 others cleared");
    step(0, 1, 2'd1, 0, 0, "R3 summary stays");
    step(1, 0, 2'd1, 32'h0000_0008, 0, "R5 set again");
    step(1, 0, 2'd0, 32'h8000_0000, 0, "R3 clear summary only");
    step(0, 1, 2'd1, 0, 0, "R3 summary reforced");
    step(1, 0, 2'd0, 32'h8000_0008, 0, "R6 clear all");
    step(0, 1, 2'd1, 0, 0, "R6 zero");
    step(1, 0, 2'd1, 32'h0000_0010, 0, "R5 prep");
    step(0, 1, 2'd0, 0, 7'h02, "R7 R10 read with event");
    step(0, 1, 2'd1, 0, 0, "R10 event kept after read");
    step(1, 0, 2'd0, 32'h0000_0002, 7'h02, "R10 w1c vs event");
    step(0, 1, 2'd1, 0, 0, "R10 event kept after w1c");
    step(0, 1, 2'd0, 0, 0, "R7 read clear");
    step(0, 1, 2'd1, 0, 0, "R7 now zero");
    check("R7 model zero", m_cause, 32'h0);
    step(1, 0, 2'd2, 32'hFFFF_FFFF, 0, "R8 mask all");
    step(0, 0, 2'd0, 0, 7'h7F, "R2 all events");
    step(0, 1, 2'd1, 0, 0, "R2 all bits");
    step(0, 1, 2'd0, 0, 0, "R7 R9 read clears irq");
    step(1, 0, 2'd3, 32'h0000_FFFF, 0, "R8 partial clear");
    step(0, 1, 2'd2, 0, 0, "R8 mask value");
    step(0, 0, 2'd0, 0, 7'h01, "R9 masked event");
    step(0, 0, 2'd0, 0, 0, "R9 idle");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule